// File: doc/BRIEF.md
# Gated-Strobe Parallel-Load Shift Register

This block is a parallel-in, serial-out shift register with a configurable stage count (eight by default). A level-sensitive load control copies a parallel word into every stage and takes priority over all other inputs. When the load control is released, the contents move one stage toward the last stage on each rising edge of an effective strobe. The effective strobe is the OR of two interchangeable inputs, a strobe and an inhibit, so either one can clock the register while the other, held high, blocks it. A serial input fills the first stage on each shift. The last stage drives a true output and its complement.

Everything runs on one fast, free-running system clock. The strobe, inhibit, mode, serial and parallel inputs are asynchronous to that clock. They pass through a synchronizer of configurable depth, and the rising edge of the OR-combined strobe is detected in the system clock domain. The block is used to turn a parallel word into a serial stream that an external, slower agent clocks out through pins.

Top module: `gated_piso_sreg`

## Requirements
- R1: An active-low reset clears every stage, so the true output is 0 and the complement is 1. The effective strobe counts as high from reset, so a strobe that is held high through reset release causes no shift.
- R2: While `mode_shift` is 0, every stage takes the matching bit of `par_in`, with bit 0 going to the first stage and bit STAGES-1 to the last. This happens whatever levels the strobe, inhibit and serial inputs have, and no shift takes place.
- R3: While `mode_shift` is 1, changes on `par_in` have no effect on the stages.
- R4: With `mode_shift` 1 and `inhibit_in` 0, each 0-to-1 transition of `strobe_in` moves every stage one position toward the last stage, and `ser_in` enters the first stage. A strobe that stays high shifts only once.
- R5: With `mode_shift` 1 and `strobe_in` 0, each 0-to-1 transition of `inhibit_in` also causes exactly one shift.
- R6: With `mode_shift` 1 and either `strobe_in` or `inhibit_in` held high, transitions on the other input cause no shift, and the contents are held.
- R7: `q_out` always equals the last stage, and `q_n_out` is always its inverse.
- R8: When `mode_shift` goes from 0 to 1 while the effective strobe is already high, the loaded value is kept. Only a later 0-to-1 transition of the effective strobe shifts.
- R9: An input change driven before system clock edge n shows at the outputs after edge n+SYNC_DEPTH, which is the third edge at the default depth of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| par_in | input | STAGES | Parallel load word; bit 0 goes to the first stage |
| ser_in | input | 1 | Serial data into the first stage |
| mode_shift | input | 1 | 1 = shift enabled, 0 = parallel load |
| strobe_in | input | 1 | Shift strobe, ORed with inhibit |
| inhibit_in | input | 1 | Inhibit, interchangeable with strobe |
| q_out | output | 1 | Last stage, true |
| q_n_out | output | 1 | Last stage, complemented |

## Verification
The register is loaded with asymmetric words while the strobe toggles, which separates a load that wins over shifting from one that loses. Shifts are then driven separately by strobe edges and by inhibit edges, with mixed serial data, so that the bit order and the source of the serial input can be seen. Gating runs hold one input high and toggle the other, which shows any OR-vs-AND confusion. Release of the load while the strobe is high, strobe pulses one cycle long, strobe levels held over many cycles, and a strobe held through reset all probe the edge detector's previous-level register. Each pattern is compared every clock against a behavioural queue model that includes the synchronizer delay.

// File: rtl/gpsr_pkg.sv
package gpsr_pkg;

   typedef struct packed {
      logic strobe;
      logic inhibit;
      logic shift_mode;
      logic ser;
   } gpsr_ctl_t;

   localparam int CTL_W = $bits(gpsr_ctl_t);

   // Reset value of the synchronized controls: strobe and inhibit read high,
   // matching the detector's previous-level reset, and load mode is active.
   localparam gpsr_ctl_t CTL_RESET = '{strobe: 1'b1, inhibit: 1'b1, shift_mode: 1'b0, ser: 1'b0};

endpackage

// File: rtl/gpsr_sync.sv
module gpsr_sync #(
   parameter int          WIDTH   = 4,
   parameter int          DEPTH   = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (DEPTH == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] pipe [DEPTH];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[0] <= RST_VAL;
            else        pipe[0] <= d;
         end
         for (genvar i = 1; i < DEPTH; i++) begin : g_flop
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[i] <= RST_VAL;
               else        pipe[i] <= pipe[i-1];
            end
         end
         assign q = pipe[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/gpsr_edge.sv
module gpsr_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic inhibit,
   input  logic enable,
   output logic fire
);

   logic combined;
   logic prev_level;

   assign combined = strobe | inhibit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_level <= 1'b1;
      else        prev_level <= combined;
   end

   assign fire = enable & combined & ~prev_level;

endmodule

// File: rtl/gpsr_chain.sv
module gpsr_chain #(
   parameter int STAGES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  logic              ser,
   input  logic [STAGES-1:0] par,
   output logic [STAGES-1:0] stages
);

   localparam int TOP = STAGES - 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     stages <= '0;
      else if (load)  stages <= par;
      else if (shift) stages <= {stages[TOP-1:0], ser};
   end

endmodule

// File: rtl/gated_piso_sreg.sv
module gated_piso_sreg
   import gpsr_pkg::*;
#(
   parameter int STAGES     = 8,
   parameter int SYNC_DEPTH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAGES-1:0] par_in,
   input  logic              ser_in,
   input  logic              mode_shift,
   input  logic              strobe_in,
   input  logic              inhibit_in,
   output logic              q_out,
   output logic              q_n_out
);

   localparam int SYNC_W = STAGES + CTL_W;
   localparam logic [SYNC_W-1:0] SYNC_RST = {{STAGES{1'b0}}, CTL_RESET};

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gated_piso_sreg: STAGES must be at least 2");
      end
      if (SYNC_DEPTH < 0) begin : g_bad_depth
         $error("gated_piso_sreg: SYNC_DEPTH must not be negative");
      end
   endgenerate

   gpsr_ctl_t         ctl_raw;
   gpsr_ctl_t         ctl_s;
   logic [SYNC_W-1:0] sync_out;
   logic [STAGES-1:0] par_s;
   logic              shld_s;
   logic              ser_s;
   logic              fire;
   logic [STAGES-1:0] stages;

   assign ctl_raw = '{strobe: strobe_in, inhibit: inhibit_in, shift_mode: mode_shift, ser: ser_in};

   gpsr_sync #(
      .WIDTH   (SYNC_W),
      .DEPTH   (SYNC_DEPTH),
      .RST_VAL (SYNC_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({par_in, ctl_raw}),
      .q     (sync_out)
   );

   assign ctl_s  = gpsr_ctl_t'(sync_out[CTL_W-1:0]);
   assign par_s  = sync_out[SYNC_W-1:CTL_W];
   assign shld_s = ctl_s.shift_mode;
   assign ser_s  = ctl_s.ser;

   gpsr_edge u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .strobe  (ctl_s.strobe),
      .inhibit (ctl_s.inhibit),
      .enable  (shld_s),
      .fire    (fire)
   );

   gpsr_chain #(.STAGES(STAGES)) u_chain (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (~shld_s),
      .shift  (fire),
      .ser    (ser_s),
      .par    (par_s),
      .stages (stages)
   );

   assign q_out   = stages[STAGES-1];
   assign q_n_out = ~stages[STAGES-1];

endmodule

// File: rtl/gated_piso_sreg_chk.sv
module gated_piso_sreg_chk #(
   parameter int STAGES = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              q_out,
   input logic              q_n_out,
   input logic              shld_s,
   input logic              ser_s,
   input logic [STAGES-1:0] par_s,
   input logic              fire,
   input logic [STAGES-1:0] stages
);

   // R2: a load cycle copies the synchronized parallel word
   p_load_copies_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !shld_s |=> stages == $past(par_s));

   // R2: no shift strobe is produced in load mode
   p_load_blocks_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !shld_s |-> !fire);

   // R4: a shift moves the contents toward the last stage, serial bit into the first
   p_shift_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> stages == {$past(stages[STAGES-2:0]), $past(ser_s)});

   // R4: a strobe edge cannot fire on two consecutive cycles
   p_single_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);

   // R6: without a detected edge in shift mode the contents are held
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (shld_s && !fire) |=> $stable(stages));

   // R7: the two outputs are always complementary
   p_complement_r7: assert property (@(posedge clk) disable iff (!rst_n)
      q_n_out == ~q_out);

endmodule

bind gated_piso_sreg gated_piso_sreg_chk #(.STAGES(STAGES)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .q_out   (q_out),
   .q_n_out (q_n_out),
   .shld_s  (shld_s),
   .ser_s   (ser_s),
   .par_s   (par_s),
   .fire    (fire),
   .stages  (stages)
);

// File: tb/gated_piso_sreg_test.sv
module gated_piso_sreg_test;

   localparam int N     = 8;
   localparam int DEPTH = 2;
   localparam int VW    = N + 4;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [N-1:0] par_in;
   logic         ser_in;
   logic         mode_shift;
   logic         strobe_in;
   logic         inhibit_in;
   logic         q_out;
   logic         q_n_out;

   int    checks = 0;
   int    fails  = 0;
   bit    comparing = 1'b0;
   bit    finished  = 1'b0;
   string tag = "R1";

   logic [N-1:0]  m_reg;
   bit            m_prev;
   logic [VW-1:0] dq[$];

   always #5 clk = ~clk;

   gated_piso_sreg #(.STAGES(N), .SYNC_DEPTH(DEPTH)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .par_in     (par_in),
      .ser_in     (ser_in),
      .mode_shift (mode_shift),
      .strobe_in  (strobe_in),
      .inhibit_in (inhibit_in),
      .q_out      (q_out),
      .q_n_out    (q_n_out)
   );

   // Reference model. The vector layout is {par, strobe, inhibit, mode, ser}.
   // Each input reaches the register DEPTH edges after it was driven.
   always @(posedge clk) begin
      if (!rst_n) begin
         m_reg  = '0;
         m_prev = 1'b1;
         dq.delete();
         for (int i = 0; i < DEPTH; i++) dq.push_back({{N{1'b0}}, 4'b1100});
      end else begin
         logic [VW-1:0] e;
         bit            lvl;
         dq.push_back({par_in, strobe_in, inhibit_in, mode_shift, ser_in});
         e   = dq.pop_front();
         lvl = e[3] | e[2];
         if (!e[1])             m_reg = e[VW-1:4];
         else if (lvl && !m_prev) m_reg = {m_reg[N-2:0], e[0]};
         m_prev = lvl;
      end
   end

   task automatic check(input string req, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (comparing && rst_n) begin
         check(tag, q_out, m_reg[N-1], "q_out");
         check("R7", q_n_out, ~m_reg[N-1], "q_n_out");
      end
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_strobe(input logic s, input int hi, input int lo);
      ser_in = s; strobe_in = 1'b1; cyc(hi);
      strobe_in = 1'b0; cyc(lo);
   endtask

   task automatic pulse_inhibit(input logic s, input int hi, input int lo);
      ser_in = s; inhibit_in = 1'b1; cyc(hi);
      inhibit_in = 1'b0; cyc(lo);
   endtask

   initial begin
      rst_n = 1'b0; par_in = '0; ser_in = 1'b1; mode_shift = 1'b1;
      strobe_in = 1'b1; inhibit_in = 1'b0;
      cyc(3);
      // R1: reset state
      check("R1", q_out, 1'b0, "q_out in reset");
      check("R1", q_n_out, 1'b1, "q_n_out in reset");
      rst_n = 1'b1;
      comparing = 1'b1;
      tag = "R1";
      cyc(6);                          // strobe held high through release: no shift
      strobe_in = 1'b0; cyc(4);
      for (int i = 0; i < N; i++) pulse_strobe(1'b0, 2, 2);

      // R2: load overrides strobe activity and serial input
      tag = "R2";
      mode_shift = 1'b0; par_in = 8'hA5; ser_in = 1'b0;
      for (int i = 0; i < 6; i++) begin strobe_in = ~strobe_in; inhibit_in = i[1]; cyc(1); end
      strobe_in = 1'b0; inhibit_in = 1'b0; cyc(4);

      // R4: shifting with strobe edges, serial pattern enters the first stage
      tag = "R4";
      mode_shift = 1'b1; cyc(4);
      for (int i = 0; i < 2 * N; i++) pulse_strobe(logic'((i % 3) == 0), 2, 2);

      // R3: parallel word changes during shift mode are ignored
      tag = "R3";
      mode_shift = 1'b0; par_in = 8'h3C; cyc(5);
      mode_shift = 1'b1; cyc(3);
      for (int i = 0; i < N; i++) begin
         par_in = 8'(8'h5A ^ (i * 37));
         pulse_strobe(1'b1, 1, 2);
      end

      // R5: inhibit edges shift while strobe is low
      tag = "R5";
      mode_shift = 1'b0; par_in = 8'h81; cyc(5);
      mode_shift = 1'b1; cyc(3);
      for (int i = 0; i < N + 2; i++) pulse_inhibit(logic'(i[0]), 2, 3);

      // R6: one input held high gates the other
      tag = "R6";
      mode_shift = 1'b0; par_in = 8'hF0; cyc(5);
      mode_shift = 1'b1; cyc(3);
      strobe_in = 1'b1; cyc(4);
      for (int i = 0; i < 6; i++) pulse_inhibit(1'b1, 2, 2);
      strobe_in = 1'b0; inhibit_in = 1'b1; cyc(4);
      for (int i = 0; i < 6; i++) pulse_strobe(1'b1, 2, 2);
      inhibit_in = 1'b0; cyc(4);
      for (int i = 0; i < N; i++) pulse_strobe(1'b0, 2, 2);

      // R8: release of load while strobe is already high
      tag = "R8";
      mode_shift = 1'b0; par_in = 8'h96; strobe_in = 1'b1; cyc(5);
      mode_shift = 1'b1; cyc(8);
      strobe_in = 1'b0; cyc(3);
      for (int i = 0; i < N; i++) pulse_strobe(1'b0, 1, 1);

      // R9: exact latency of a load, checked without the model
      comparing = 1'b0;
      mode_shift = 1'b0; par_in = 8'h00; cyc(6);
      par_in = 8'h80; cyc(1);
      check("R9", q_out, 1'b0, "after 1 edge");
      cyc(1);
      check("R9", q_out, 1'b0, "after 2 edges");
      cyc(1);
      check("R9", q_out, 1'b1, "after 3 edges");
      check("R7", q_n_out, 1'b0, "complement after load");
      comparing = 1'b1;

      // R4: a long strobe level shifts once
      tag = "R4";
      mode_shift = 1'b1; par_in = 8'h40; cyc(4);
      pulse_strobe(1'b0, 12, 3);
      pulse_strobe(1'b0, 12, 3);
      cyc(4);

      comparing = 1'b0;
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #2000000;
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule